// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card-side clock for an SD host from the system clock. A single control word, written through a plain write/read port, holds a 7-bit divisor, a run-enable bit, a force-off bit and a stored high-speed flag. While the clock runs, its frequency is sysclk / (2 × (div + 1)). The fastest setting is sysclk / 2 with div = 0, and the slowest uses div = 127.

Besides the divided clock level, the block drives two single-cycle strobes that the card protocol logic can use as clock enables in the system-clock domain. One marks each rising transition of the card clock and the other marks each falling transition. A divisor written while the clock runs is held back until the next falling transition, so every period uses one divisor for both of its halves. After reset the card clock stays low until software writes a word that enables it.

Top module: `sd_clk_divider`

## Requirements
- R1: Following reset, card_clk, card_rise and card_fall are 0 and cfg_rdata is 0. The card clock makes no transition until a write sets the enable bit.
- R2: cfg_rdata returns the last written word. Bits 6:0 hold the divisor, bit 7 the enable, bit 8 the force-off and bit 9 the high-speed flag. hs_timing follows bit 9.
- R3: With enable = 1 and force-off = 0, card_clk is high for div+1 cycles and low for div+1 cycles, for every div from 0 to 127.
- R4: When a write starts a stopped clock, the first rising transition of card_clk happens on the (div+2)-th rising sysclk edge after the edge that captures the write.
- R5: Whenever force-off is 1, card_clk is 0 from the next cycle on, whatever the enable bit holds, and it stays 0 while the bit remains set.
- R6: Clearing the enable bit drives card_clk to 0 from the next cycle on, and it stays 0.
- R7: A divisor written while the clock runs leaves the current phase and any high phase that is in progress at their old length. The new value applies from the next falling transition onward, so each low phase equals the high phase that follows it.
- R8: card_rise is 1 exactly in the cycles where card_clk has just gone from 0 to 1, and card_fall is 1 exactly where it has just gone from 1 to 0. The two strobes are never 1 together.
- R9: The high-speed bit is stored and reported, but it has no effect on the card clock timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 10 | Control word to write |
| cfg_rdata | output | 10 | Current control word |
| card_clk | output | 1 | Divided card clock level |
| card_rise | output | 1 | One-cycle strobe on each rising transition of card_clk |
| card_fall | output | 1 | One-cycle strobe on each falling transition of card_clk |
| hs_timing | output | 1 | Stored high-speed flag |

## Verification
The assertions assume that cfg_we and cfg_wdata are always known and change only away from the rising clock edge. They accept a write in any cycle and any bit pattern, including a divisor change in the middle of a phase. The stimulus drives every write on the falling edge. It takes random 7-bit divisors and random high-speed flags from a fixed seed, and it stops the clock between random settings so that each measured period belongs to one divisor. Directed cases cover div 0 and 127, force-off while running, clearing the enable bit, and a divisor change in the middle of a high phase.

// File: rtl/sdclk_pkg.sv
// Package: shared types for the SD card clock divider.
// Assumes: the control word places the flag bits directly above the divisor.
package sdclk_pkg;

    // Default divisor width, which sets the slowest achievable rate.
    localparam int SDCLK_DIV_W_DEF = 7;
    // Number of flag bits stored above the divisor.
    localparam int SDCLK_FLAG_W    = 3;

    // Control flags decoded from the control word.
    typedef struct packed {
        logic hs;   // high-speed timing request, stored only
        logic off;  // force the card clock low
        logic en;   // run the card clock
    } sdclk_flags_t;

endpackage

// File: rtl/sdclk_ctrl_reg.sv
// Module: control word register.
// Holds the divisor and flag bits, returns them on the read port and splits
// them into fields. Assumes writes come only from the host side of the chip.
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int DIV_W  = SDCLK_DIV_W_DEF,
    localparam int CTRL_W = DIV_W + SDCLK_FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic [DIV_W-1:0]  div_o,
    output sdclk_flags_t      flags_o
);

    logic [CTRL_W-1:0] word_q;

    // Capture the control word on a write; it clears to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we) begin
            word_q <= wdata;
        end
    end

    // Present the stored word and its decoded fields.
    always_comb begin
        rdata       = word_q;
        div_o       = word_q[DIV_W-1:0];
        flags_o.en  = word_q[DIV_W];
        flags_o.off = word_q[DIV_W+1];
        flags_o.hs  = word_q[DIV_W+2];
    end

endmodule

// File: rtl/sdclk_div_shadow.sv
// Module: active divisor shadow register.
// Copies the programmed divisor into the working copy only when the phase
// generator asks for it (while idle or at a falling transition). Assumes load
// never arrives in the middle of a period.
module sdclk_div_shadow #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_new,
    input  logic             card_clk,
    output logic [DIV_W-1:0] div_act
);

    // Refresh the working divisor only on a load request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act <= '0;
        end else if (load) begin
            div_act <= div_new;
        end
    end

    // R7: the working divisor does not change inside a high phase.
    p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk && $past(card_clk)) |-> $stable(div_act))
        else $error("working divisor changed during a high phase");

endmodule

// File: rtl/sdclk_phase_gen.sv
// Module: half-period counter and card clock toggle.
// Counts div_act+1 system cycles per half period, toggles the card clock and
// produces registered edge strobes that line up with the new level. A start
// spends one arming cycle so the shadow can take the fresh divisor. A stop
// drops the clock at once. Assumes div_act changes only when load is high.
module sdclk_phase_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_act,
    output logic             load,
    output logic             card_clk,
    output logic             rise_o,
    output logic             fall_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             armed_q;
    logic             clk_q;
    logic             terminal;

    // The end of the current half period.
    assign terminal = (cnt_q == div_act);

    // Ask for a new divisor while idle or at the end of a high phase.
    assign load = !armed_q || (terminal && clk_q);

    // Advance the half-period counter and toggle the clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            clk_q   <= 1'b0;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            clk_q   <= 1'b0;
            rise_o  <= 1'b0;
            fall_o  <= clk_q;
        end else if (!armed_q) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else if (terminal) begin
            cnt_q   <= '0;
            clk_q   <= !clk_q;
            rise_o  <= !clk_q;
            fall_o  <= clk_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end
    end

    assign card_clk = clk_q;

    // R3: the counter never passes the working divisor.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_act)
        else $error("half-period counter overran the divisor");

    // R8: the rise strobe marks a 0 to 1 transition.
    p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (clk_q && !$past(clk_q)))
        else $error("rise strobe without a rising transition");

    // R8: the fall strobe marks a 1 to 0 transition.
    p_fall_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!clk_q && $past(clk_q)))
        else $error("fall strobe without a falling transition");

    // R8: the two strobes are mutually exclusive.
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}))
        else $error("both edge strobes active");

endmodule

// File: rtl/sd_clk_divider.sv
// Module: SD card clock divider top.
// Ties the control register, the divisor shadow and the phase generator
// together. The card clock runs at sysclk/(2*(div+1)) while the enable bit is
// set and the force-off bit is clear. Assumes one system clock domain and a
// synchronous active-low reset.
module sd_clk_divider
    import sdclk_pkg::*;
#(
    parameter int DIV_W  = SDCLK_DIV_W_DEF,
    localparam int CTRL_W = DIV_W + SDCLK_FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              card_clk,
    output logic              card_rise,
    output logic              card_fall,
    output logic              hs_timing
);

    logic [DIV_W-1:0] div_prog;
    logic [DIV_W-1:0] div_act;
    sdclk_flags_t     flags;
    logic             run;
    logic             load;

    sdclk_ctrl_reg #(.DIV_W(DIV_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .div_o   (div_prog),
        .flags_o (flags)
    );

    // The clock runs only when it is enabled and not forced off.
    assign run       = flags.en && !flags.off;
    assign hs_timing = flags.hs;

    sdclk_div_shadow #(.DIV_W(DIV_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .div_new  (div_prog),
        .card_clk (card_clk),
        .div_act  (div_act)
    );

    sdclk_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_act  (div_act),
        .load     (load),
        .card_clk (card_clk),
        .rise_o   (card_rise),
        .fall_o   (card_fall)
    );

    // R5: a set force-off bit holds the card clock low from the next cycle.
    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags.off |=> !card_clk)
        else $error("card clock high while forced off");

    // R6: a clear enable bit holds the card clock low from the next cycle.
    p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.en |=> !card_clk)
        else $error("card clock high while disabled");

    // R1: a stopped clock makes no transition.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (!card_rise && !card_clk))
        else $error("transition while stopped");

endmodule

// File: tb/tb_sd_clk_divider.sv
module tb_sd_clk_divider;

    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] cfg_rdata;
    logic       card_clk, card_rise, card_fall, hs_timing;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int ph [0:15];

    always #2 clk = ~clk;

    sd_clk_divider dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .card_clk(card_clk), .card_rise(card_rise),
        .card_fall(card_fall), .hs_timing(hs_timing)
    );

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Build a control word from its fields.
    function automatic logic [9:0] word(input int d, input bit en, input bit off, input bit hs);
        return {hs, off, en, d[6:0]};
    endfunction

    // Write one word; called on a falling edge and returns on the next one.
    task automatic wr(input logic [9:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Record n complete phase lengths and check the strobes on every cycle.
    task automatic collect(input int n);
        logic prev;
        int len, idx, guard, bad;
        prev = card_clk; len = 0; idx = -1; guard = 0; bad = 0;
        while (idx < n && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (card_rise !== (card_clk && !prev) || card_fall !== (!card_clk && prev))
                bad++;
            if (card_clk != prev) begin
                if (idx >= 0) ph[idx] = len;
                idx++;
                len = 1;
            end else begin
                len++;
            end
            prev = card_clk;
        end
        check(bad == 0, "R8 strobe alignment", bad, 0);
        check(idx >= n, "R3 phases observed", idx, n);
    endtask

    // Expected phase length is div+1 for every recorded phase.
    task automatic check_phases(input int n, input int d, input string req);
        for (int i = 0; i < n; i++)
            check(ph[i] == d + 1, req, ph[i], d + 1);
    endtask

    // From a stopped clock, start with divisor d and check latency and period.
    task automatic start_and_measure(input int d, input bit hs, input int n, input string req);
        int k;
        wr(word(d, 1'b1, 1'b0, hs));
        k = 1;
        while (card_clk == 1'b0 && k < 400) begin
            @(negedge clk);
            k++;
        end
        // The rise lands on sysclk edge d+2 after the capture edge, seen one half cycle later.
        check(k == d + 3, "R4 first rise latency", k, d + 3);
        collect(n);
        check_phases(n, d, req);
        check(hs_timing == hs, "R2 hs_timing follows bit 9", hs_timing, hs);
        wr(10'h000);
    endtask

    initial begin
        int seen, cnt, lo, d;
        bit hs;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(negedge clk);
        check(card_clk == 1'b0 && card_rise == 1'b0 && card_fall == 1'b0, "R1 outputs at reset",
              {card_clk, card_rise, card_fall}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 10'h000, "R1 rdata after reset", cfg_rdata, 0);
        seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (card_clk || card_rise) seen++;
        end
        check(seen == 0, "R1 stopped until written", seen, 0);

        // R2 and R5: read back every field while forced off
        wr(word(43, 1'b1, 1'b1, 1'b1));
        check(cfg_rdata == 10'h3AB, "R2 readback", cfg_rdata, 10'h3AB);
        check(hs_timing == 1'b1, "R2 hs flag", hs_timing, 1);
        seen = 0;
        repeat (80) begin
            @(negedge clk);
            if (card_clk) seen++;
        end
        check(seen == 0, "R5 forced off with enable set", seen, 0);
        wr(10'h000);

        // R3 and R4: directed extremes
        start_and_measure(0, 1'b0, 8, "R3 div=0 phase");
        start_and_measure(1, 1'b0, 6, "R3 div=1 phase");
        start_and_measure(127, 1'b0, 4, "R3 div=127 phase");
        // R9: the high-speed bit leaves timing unchanged
        start_and_measure(2, 1'b1, 6, "R9 high-speed has no effect");

        // R3/R9: constrained-random divisors and flags
        for (int i = 0; i < 10; i++) begin
            d = int'($urandom % 128);
            hs = bit'($urandom % 2);
            start_and_measure(d, hs, 4, "R3 random divisor phase");
        end

        // R7: change the divisor in the middle of a high phase
        wr(word(20, 1'b1, 1'b0, 1'b0));
        while (card_clk == 1'b0) @(negedge clk);
        cnt = 1;
        repeat (5) begin
            @(negedge clk);
            if (card_clk) cnt++;
        end
        wr(word(3, 1'b1, 1'b0, 1'b0));
        if (card_clk) cnt++;
        while (card_clk == 1'b1) begin
            @(negedge clk);
            if (card_clk) cnt++;
        end
        check(cnt == 21, "R7 high phase keeps old length", cnt, 21);
        lo = 1;
        @(negedge clk);
        while (card_clk == 1'b0 && lo < 100) begin
            lo++;
            @(negedge clk);
        end
        check(lo == 4, "R7 next low phase uses new divisor", lo, 4);
        collect(4);
        check_phases(4, 3, "R7 phases after change");

        // R5: force off while running, then release
        wr(word(3, 1'b1, 1'b1, 1'b0));
        @(negedge clk);
        seen = 0;
        repeat (40) begin
            if (card_clk) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R5 force-off while running", seen, 0);
        wr(10'h000);
        start_and_measure(3, 1'b0, 4, "R5 resume after force-off");

        // R6: clear the enable bit while running
        wr(word(5, 1'b1, 1'b0, 1'b0));
        collect(3);
        wr(word(5, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        seen = 0;
        repeat (40) begin
            if (card_clk) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R6 enable cleared holds low", seen, 0);
        check(cfg_rdata == 10'h005, "R2 readback after stop", cfg_rdata, 10'h005);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule